// File: doc/BRIEF.md
# Data Address Watch Unit

This block sits beside a load/store pipeline and watches every data access. Each access presents an address and a store flag for one cycle. The block compares the address against two programmable watch addresses and raises a one-cycle breakpoint pulse on a match. It also flags misaligned word accesses as data-abort requests when alignment checking is on. Before any comparison, the block can move the address into a per-process region: a non-zero process tag is placed in the top seven address bits whenever those bits of the access are all zero.

All configuration arrives through a single write port that selects one register per write. When debug is enabled, a breakpoint hit latches a pending debug entry with a fixed entry-reason code. Further hits are held off until the core acknowledges the entry. Alignment aborts taken while debug is enabled record a fault status code and the address of the abort. Taking the exception is left to the core.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset, bkptHit, abortReq, dbgPending, entryCode, faultStatus and faultAddr are all zero, and every configuration field is zero.
- R2: Write select 0 loads watch address A and select 1 loads watch address B. Select 2 loads the match control: bits 1:0 are the enable field of comparator A, bits 3:2 that of comparator B, and bit 8 is mask mode. Select 3 loads the system control: bit 0 enables alignment checking and bits 31:25 hold the process tag. Select 4 loads the debug control, whose bit 31 is debug enable. Other selects change nothing.
- R3: An enable field of 0 never matches, 1 matches stores only, 2 matches loads and stores, and 3 matches loads only.
- R4: Outside mask mode, each comparator matches when the effective address with bits 1:0 cleared equals its watch address with bits 1:0 cleared.
- R5: In mask mode, address bits that are set in watch address B are ignored when comparing against watch address A (all 32 bits otherwise compared), and comparator B never matches.
- R6: With alignment checking on, an access whose address bits 1:0 are non-zero pulses abortReq; with it off, no abort is raised.
- R7: The effective address equals the access address, except when the process tag is non-zero and access bits 31:25 are all zero; in that case the tag replaces bits 31:25.
- R8: A breakpoint hit with debug enabled sets dbgPending and sets entryCode to 2. With debug disabled, a hit leaves both unchanged.
- R9: While dbgPending is set, matching accesses raise no bkptHit. A dbgAck clears dbgPending and entryCode to zero.
- R10: An alignment abort with debug enabled loads faultStatus with 1 and faultAddr with the effective address. With debug disabled, both keep their values.
- R11: bkptHit and abortReq are registered single-cycle pulses in the cycle after the access is presented with accValid high; without accValid they stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration register select |
| cfgData | input | 32 | Configuration write data |
| accValid | input | 1 | Access presented this cycle |
| accAddr | input | 32 | Access address |
| accStore | input | 1 | 1 for a store, 0 for a load |
| dbgAck | input | 1 | Acknowledge and clear a pending debug entry |
| bkptHit | output | 1 | Breakpoint match pulse |
| abortReq | output | 1 | Misaligned-access abort pulse |
| dbgPending | output | 1 | Debug entry pending |
| entryCode | output | 4 | Debug entry reason code |
| faultStatus | output | 4 | Captured fault status |
| faultAddr | output | 32 | Captured fault address |

## Verification
The assertions assume that dbgAck is never high in the same cycle as an access that would hit, and that configuration writes never coincide with an access. Under these assumptions the pending and capture checks relate one cycle to the next without races. The stimulus keeps to these rules in every test. Each access is a single accValid cycle, and the bench separates it from any register write or acknowledge by at least one idle cycle. The sweeps also keep debug disabled except in the dedicated debug tests, so that the pending state does not suppress hits the sweeps expect.

// File: rtl/awu_pkg.sv
package awu_pkg;
  localparam logic [1:0] EN_OFF        = 2'd0;
  localparam logic [1:0] EN_STORE_ONLY = 2'd1;
  localparam logic [1:0] EN_ANY        = 2'd2;
  localparam logic [1:0] EN_LOAD_ONLY  = 2'd3;

  localparam logic [3:0] ENTRY_DATA_BKPT = 4'd2;
  localparam logic [3:0] FSTAT_ALIGN     = 4'd1;

  localparam logic [2:0] SEL_ADDR_A = 3'd0;
  localparam logic [2:0] SEL_ADDR_B = 3'd1;
  localparam logic [2:0] SEL_MATCH  = 3'd2;
  localparam logic [2:0] SEL_SYS    = 3'd3;
  localparam logic [2:0] SEL_DEBUG  = 3'd4;

  typedef struct packed {
    logic hitStb;
    logic abortStb;
    logic captStb;
  } awu_strobe_t;
endpackage

// File: rtl/awu_datapath.sv
module awu_datapath
  import awu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_LSB = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accStore,
  input  awu_strobe_t       strb,
  output logic              match,
  output logic              misal,
  output logic              alignChk,
  output logic              dbgEn,
  output logic [3:0]        faultStatus,
  output logic [ADDR_W-1:0] faultAddr
);
  localparam int TAG_W = ADDR_W - TAG_LSB;
  localparam int NUM_CMP = 2;

  logic [ADDR_W-1:0] watchAddr [NUM_CMP];
  logic [1:0]        enField   [NUM_CMP];
  logic              maskMode;
  logic [TAG_W-1:0]  procTag;
  logic [ADDR_W-1:0] effAddr;
  logic [NUM_CMP-1:0] cmpHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        watchAddr[i] <= '0;
        enField[i]   <= EN_OFF;
      end
      maskMode <= 1'b0;
      alignChk <= 1'b0;
      procTag  <= '0;
      dbgEn    <= 1'b0;
    end else if (cfgWrEn) begin
      case (cfgSel)
        SEL_ADDR_A: watchAddr[0] <= cfgData;
        SEL_ADDR_B: watchAddr[1] <= cfgData;
        SEL_MATCH: begin
          enField[0] <= cfgData[1:0];
          enField[1] <= cfgData[3:2];
          maskMode   <= cfgData[8];
        end
        SEL_SYS: begin
          alignChk <= cfgData[0];
          procTag  <= cfgData[ADDR_W-1:TAG_LSB];
        end
        SEL_DEBUG: dbgEn <= cfgData[ADDR_W-1];
        default: ;
      endcase
    end
  end

  always_comb begin
    effAddr = accAddr;
    if (procTag != '0 && accAddr[ADDR_W-1:TAG_LSB] == '0)
      effAddr[ADDR_W-1:TAG_LSB] = procTag;
  end

  assign misal = accAddr[1:0] != 2'b00;

  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmp
    logic kindOk;
    logic addrEq;
    assign kindOk = (enField[g] != EN_OFF) &&
                    (accStore ? (enField[g] != EN_LOAD_ONLY) : (enField[g] != EN_STORE_ONLY));
    if (g == 0) begin : gFirst
      assign addrEq = maskMode
        ? (((effAddr ^ watchAddr[0]) & ~watchAddr[1]) == '0)
        : (effAddr[ADDR_W-1:2] == watchAddr[0][ADDR_W-1:2]);
      assign cmpHit[g] = kindOk && addrEq;
    end else begin : gOther
      assign addrEq = effAddr[ADDR_W-1:2] == watchAddr[g][ADDR_W-1:2];
      assign cmpHit[g] = kindOk && addrEq && !maskMode;
    end
  end

  assign match = |cmpHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultStatus <= '0;
      faultAddr   <= '0;
    end else if (strb.captStb) begin
      faultStatus <= FSTAT_ALIGN;
      faultAddr   <= effAddr;
    end
  end

  // R10: the fault address only moves after an abort taken with debug on
  a_r10_capture_gated: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(faultAddr) |-> $past(dbgEn && accValid && alignChk && misal));
  // R6: misalignment flag follows the low address bits
  a_r6_misal_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accAddr[1:0] == 2'b00) |-> !misal);
endmodule

// File: rtl/awu_control.sv
module awu_control
  import awu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        match,
  input  logic        misal,
  input  logic        alignChk,
  input  logic        dbgEn,
  input  logic        dbgAck,
  output awu_strobe_t strb,
  output logic        bkptHit,
  output logic        abortReq,
  output logic        dbgPending,
  output logic [3:0]  entryCode
);
  logic hitNow;
  logic abortNow;

  assign hitNow   = accValid && match && !dbgPending;
  assign abortNow = accValid && alignChk && misal;

  always_comb begin
    strb.hitStb   = hitNow;
    strb.abortStb = abortNow;
    strb.captStb  = abortNow && dbgEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bkptHit    <= 1'b0;
      abortReq   <= 1'b0;
      dbgPending <= 1'b0;
      entryCode  <= '0;
    end else begin
      bkptHit  <= strb.hitStb;
      abortReq <= strb.abortStb;
      if (strb.hitStb && dbgEn) begin
        dbgPending <= 1'b1;
        entryCode  <= ENTRY_DATA_BKPT;
      end else if (dbgAck) begin
        dbgPending <= 1'b0;
        entryCode  <= '0;
      end
    end
  end

  // R11: pulses only follow a presented access
  a_r11_hit_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    bkptHit |-> $past(accValid));
  a_r11_abort_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> $past(accValid));
  // R9: pending blocks further hits and holds until acknowledged
  a_r9_no_hit_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    dbgPending |=> !bkptHit);
  a_r9_pending_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dbgPending && !dbgAck) |=> dbgPending);
  // R8: a new pending entry carries the data breakpoint code and needs debug on
  a_r8_entry_code: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgPending) |-> (entryCode == ENTRY_DATA_BKPT && $past(dbgEn)));
  // R6: an abort needs alignment checking on
  a_r6_abort_needs_check: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> $past(alignChk));
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_LSB = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accStore,
  input  logic              dbgAck,
  output logic              bkptHit,
  output logic              abortReq,
  output logic              dbgPending,
  output logic [3:0]        entryCode,
  output logic [3:0]        faultStatus,
  output logic [ADDR_W-1:0] faultAddr
);
  awu_strobe_t strb;
  logic match, misal, alignChk, dbgEn;

  awu_datapath #(.ADDR_W(ADDR_W), .TAG_LSB(TAG_LSB)) uDp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .accValid(accValid), .accAddr(accAddr), .accStore(accStore), .strb(strb),
    .match(match), .misal(misal), .alignChk(alignChk), .dbgEn(dbgEn),
    .faultStatus(faultStatus), .faultAddr(faultAddr)
  );

  awu_control uCtl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .match(match), .misal(misal),
    .alignChk(alignChk), .dbgEn(dbgEn), .dbgAck(dbgAck), .strb(strb),
    .bkptHit(bkptHit), .abortReq(abortReq), .dbgPending(dbgPending),
    .entryCode(entryCode)
  );
endmodule

// File: tb/addr_watch_unit_test.sv
module addr_watch_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgSel = '0;
  logic [31:0] cfgData = '0;
  logic accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic accStore = 1'b0;
  logic dbgAck = 1'b0;
  logic bkptHit, abortReq, dbgPending;
  logic [3:0] entryCode, faultStatus;
  logic [31:0] faultAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench copies of programmed values
  logic [31:0] mA = '0, mB = '0;
  logic [1:0] mEnA = '0, mEnB = '0;
  logic mMask = 0, mAlign = 0;
  logic [6:0] mTag = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_watch_unit uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .accValid(accValid), .accAddr(accAddr), .accStore(accStore), .dbgAck(dbgAck),
    .bkptHit(bkptHit), .abortReq(abortReq), .dbgPending(dbgPending),
    .entryCode(entryCode), .faultStatus(faultStatus), .faultAddr(faultAddr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWrEn = 0;
    case (sel)
      3'd0: mA = d;
      3'd1: mB = d;
      3'd2: begin mEnA = d[1:0]; mEnB = d[3:2]; mMask = d[8]; end
      3'd3: begin mAlign = d[0]; mTag = d[31:25]; end
      default: ;
    endcase
  endtask

  // drive one access; outputs are checked at the following negedge
  task automatic acc(logic [31:0] a, logic st);
    @(negedge clk);
    accValid = 1; accAddr = a; accStore = st;
    @(negedge clk);
    accValid = 0;
  endtask

  function automatic logic [31:0] effOf(logic [31:0] a);
    return (mTag != 0 && a[31:25] == 0) ? {mTag, a[24:0]} : a;
  endfunction

  function automatic bit kindOk(logic [1:0] en, logic st);
    case (en)
      2'd1: return st;
      2'd2: return 1'b1;
      2'd3: return !st;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit expHit(logic [31:0] a, logic st);
    logic [31:0] e = effOf(a);
    bit h0, h1;
    if (mMask) begin
      h0 = kindOk(mEnA, st) && ((e & ~mB) == (mA & ~mB));
      h1 = 0;
    end else begin
      h0 = kindOk(mEnA, st) && (e[31:2] == mA[31:2]);
      h1 = kindOk(mEnB, st) && (e[31:2] == mB[31:2]);
    end
    return h0 || h1;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bkptHit", {31'b0, bkptHit}, 0);
    chk("R1 abortReq", {31'b0, abortReq}, 0);
    chk("R1 dbgPending", {31'b0, dbgPending}, 0);
    chk("R1 entryCode", {28'b0, entryCode}, 0);
    chk("R1 faultStatus", {28'b0, faultStatus}, 0);
    chk("R1 faultAddr", faultAddr, 0);
    rstN = 1;
    acc(32'h0, 0);
    chk("R1 reset config no hit", {31'b0, bkptHit}, 0);

    // R3 R4 sweep of enables, kind, target and low bits
    wr(3'd0, 32'h4000_1230);
    wr(3'd1, 32'h4000_5674);
    for (int e0 = 0; e0 < 4; e0++)
      for (int e1 = 0; e1 < 4; e1++) begin
        wr(3'd2, {28'b0, e1[1:0], e0[1:0]});
        for (int st = 0; st < 2; st++)
          for (int tg = 0; tg < 3; tg++)
            for (int off = 0; off < 4; off++) begin
              logic [31:0] a = (tg == 0) ? (32'h4000_1230 | off) :
                               (tg == 1) ? (32'h4000_5674 | off) : (32'h4000_9990 | off);
              acc(a, st[0]);
              chk("R3 R4 sweep hit", {31'b0, bkptHit}, {31'b0, expHit(a, st[0])});
              chk("R11 no abort while check off", {31'b0, abortReq}, 0);
            end
      end

    // R11 pulse is single-cycle and absent without accValid
    wr(3'd2, 32'h0000_000A);
    acc(32'h4000_1230, 0);
    chk("R11 hit pulse", {31'b0, bkptHit}, 1);
    @(negedge clk);
    chk("R11 pulse ends", {31'b0, bkptHit}, 0);
    accAddr = 32'h4000_1230;
    @(negedge clk);
    chk("R11 no access no hit", {31'b0, bkptHit}, 0);

    // R5 mask mode sweep
    wr(3'd0, 32'h1234_5670);
    wr(3'd1, 32'h0000_00F3);
    wr(3'd2, 32'h0000_010A);
    for (int k = 0; k < 32; k++) begin
      logic [31:0] a = 32'h1234_5600 | (k[4:0] << 3) | k[1:0];
      acc(a, k[2]);
      chk("R5 mask compare", {31'b0, bkptHit}, {31'b0, expHit(a, k[2])});
    end
    acc(32'h1234_5771, 0);
    chk("R5 unmasked bit differs", {31'b0, bkptHit}, 0);
    acc(32'h0000_00F0, 0);
    chk("R5 comparator B off in mask mode", {31'b0, bkptHit}, 0);

    // R2 unused select changes nothing
    wr(3'd2, 32'h0000_0002);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_0000);
    acc(32'h1234_5670, 1);
    chk("R2 ignored select keeps config", {31'b0, bkptHit}, 1);

    // R6 alignment sweep
    for (int ck = 0; ck < 2; ck++) begin
      wr(3'd3, {31'b0, ck[0]});
      for (int off = 0; off < 4; off++) begin
        acc(32'h0000_2000 | off, off[0]);
        chk("R6 abort", {31'b0, abortReq}, {31'b0, (ck == 1) && (off != 0)});
        chk("R10 no capture without debug", faultAddr, 0);
      end
    end

    // R7 relocation
    wr(3'd3, {7'h05, 25'b0});
    wr(3'd0, 32'h0A00_1000);
    wr(3'd2, 32'h0000_0002);
    acc(32'h0000_1000, 0);
    chk("R7 relocated hit", {31'b0, bkptHit}, 1);
    acc(32'h0200_1000, 0);
    chk("R7 high bits set not relocated", {31'b0, bkptHit}, 0);
    wr(3'd3, 32'h0);
    acc(32'h0000_1000, 0);
    chk("R7 zero tag no relocation", {31'b0, bkptHit}, 0);

    // R10 capture with debug on
    wr(3'd4, 32'h8000_0000);
    wr(3'd3, {7'h05, 24'b0, 1'b1});
    acc(32'h0000_3003, 1);
    chk("R10 status", {28'b0, faultStatus}, 1);
    chk("R10 address", faultAddr, 32'h0A00_3003);

    // R8 R9 debug pending
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h5000_0000);
    acc(32'h5000_0000, 0);
    chk("R8 hit", {31'b0, bkptHit}, 1);
    chk("R8 pending", {31'b0, dbgPending}, 1);
    chk("R8 code", {28'b0, entryCode}, 2);
    acc(32'h5000_0000, 0);
    chk("R9 suppressed", {31'b0, bkptHit}, 0);
    @(negedge clk); dbgAck = 1; @(negedge clk); dbgAck = 0;
    chk("R9 ack clears pending", {31'b0, dbgPending}, 0);
    chk("R9 ack clears code", {28'b0, entryCode}, 0);
    acc(32'h5000_0000, 0);
    chk("R9 hit after ack", {31'b0, bkptHit}, 1);
    @(negedge clk); dbgAck = 1; @(negedge clk); dbgAck = 0;
    wr(3'd4, 32'h7FFF_FFFF);
    acc(32'h5000_0000, 0);
    chk("R8 hit with debug off", {31'b0, bkptHit}, 1);
    chk("R8 no pending with debug off", {31'b0, dbgPending}, 0);
    chk("R8 no code with debug off", {28'b0, entryCode}, 0);

    finish();
  end
endmodule